// File: doc/BRIEF.md
# Raster Bad-Line CPU Stall Generator

This block tracks the position within each 63-cycle raster line of a PAL video controller. On every line that needs a fresh character fetch it drives the two bus-arbitration signals that hold off the CPU. The rest of the controller supplies the current raster line, a 3-bit vertical fine-scroll value and a display-enable bit. The block returns the cycle index within the line, a bad-line flag, a bus-available signal and an address-enable signal.

On a bad line the CPU first gets a run of free cycles. Bus-available then drops, and the CPU receives three cycles in which it may still complete writes. After that, address-enable drops for the 40-cycle fetch window. The line ends with free cycles again. On every other line both signals stay high. Only the character-fetch stall is modelled. The reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `raster_stall_gen`

## Requirements
- R1: `cycle_idx` steps by one on every clock from 0 up to 62, then returns to 0 on the next clock.
- R2: While `rst_n` is low, `cycle_idx` is 0 and `ba`, `aec` are 1. After `rst_n` rises, `cycle_idx` stays 0 for two clocks and then starts counting.
- R3: `bad_line` is 1 exactly when `raster_line` is in 0x30..0xF7, `raster_line[2:0]` equals `yscroll`, and the display-enable condition of R4 holds.
- R4: The display-enable condition holds when `den` was 1 during line 0x30 of the current frame. The condition is kept until `raster_line` drops below 0x30. `den` on any other line has no effect.
- R5: On a bad line, cycles 0..10 are free, with `ba`=1 and `aec`=1.
- R6: On a bad line, cycles 11..13 are write-only, with `ba`=0 and `aec`=1.
- R7: On a bad line, cycles 14..53 are stolen, with `ba`=0 and `aec`=0.
- R8: On a bad line, cycles 54..62 are free, with `ba`=1 and `aec`=1.
- R9: On a line that is not a bad line, all 63 cycles are free.
- R10: With `yscroll`=3 and display enabled during line 0x30, line 0x83 is a bad line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock, one edge per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| raster_line | input | 9 | Current raster line number |
| yscroll | input | 3 | Vertical fine-scroll value |
| den | input | 1 | Display enable |
| ba | output | 1 | Bus available (1 = CPU may read and write) |
| aec | output | 1 | Address enable for CPU (0 = bus taken by video) |
| bad_line | output | 1 | Current line is a bad line |
| cycle_idx | output | 6 | Cycle index within the raster line |

## Verification
The assertions assume that `raster_line`, `yscroll` and `den` change only in the clock after `cycle_idx` wraps to 0, so each signal holds one value across a whole line. They also assume that `raster_line` starts each frame at 0 and counts upward. The stimulus keeps to this by updating these inputs only in the clock where its own line counter wraps. It walks four full 312-line frames with different scroll values and display-enable patterns, including a frame where `den` is set on every line except 0x30.

// File: rtl/raster_stall_pkg.sv
package raster_stall_pkg;
  // Bus ownership class of one cycle of a raster line.
  typedef enum logic [1:0] {
    SLOT_FREE   = 2'd0,
    SLOT_WONLY  = 2'd1,
    SLOT_STOLEN = 2'd2
  } slot_e;
endpackage

// File: rtl/rsg_cycle_ctr.sv
module rsg_cycle_ctr #(
  parameter int LINE_CYCLES = 63,
  parameter int CYC_W       = $clog2(LINE_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CYC_W-1:0] cyc_q
);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(LINE_CYCLES - 1);

  logic             cnt_en;
  logic [CYC_W-1:0] cyc_d;

  assign cnt_en = 1'b1;

  always_comb begin
    cyc_d = cyc_q;
    if (cnt_en) begin
      if (cyc_q == LAST_CYC) cyc_d = '0;
      else                   cyc_d = cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_d;
  end

  // R1: wrap after the last cycle of the line
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == LAST_CYC) |=> (cyc_q == '0));

  // R1: unit step everywhere else
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != LAST_CYC) |=> (cyc_q == $past(cyc_q) + 1'b1));
endmodule

// File: rtl/rsg_badline_det.sv
module rsg_badline_det #(
  parameter int LINE_W     = 9,
  parameter int YS_W       = 3,
  parameter int FIRST_LINE = 'h30,
  parameter int LAST_LINE  = 'hF7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] raster_line,
  input  logic [YS_W-1:0]   yscroll,
  input  logic              den,
  output logic              bad_line
);
  localparam logic [LINE_W-1:0] FIRST_L = LINE_W'(FIRST_LINE);
  localparam logic [LINE_W-1:0] LAST_L  = LINE_W'(LAST_LINE);

  logic den_seen_q, den_seen_d;
  logic on_first, in_window, scroll_hit, den_ok;

  assign on_first   = (raster_line == FIRST_L);
  assign in_window  = (raster_line >= FIRST_L) && (raster_line <= LAST_L);
  assign scroll_hit = (raster_line[YS_W-1:0] == yscroll);
  assign den_ok     = den_seen_q || (on_first && den);

  always_comb begin
    den_seen_d = den_seen_q;
    if (raster_line < FIRST_L)  den_seen_d = 1'b0;
    else if (on_first && den)   den_seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) den_seen_q <= 1'b0;
    else        den_seen_q <= den_seen_d;
  end

  assign bad_line = in_window && scroll_hit && den_ok;

  // R4: the enable memory is only set by display enable seen on the first line
  a_r4_set_on_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(den_seen_q) |-> ($past(raster_line) == FIRST_L) && $past(den));

  // R4: the enable memory is cleared above the display window
  a_r4_clear_above: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(raster_line) < FIRST_L) |-> !den_seen_q);
endmodule

// File: rtl/rsg_stall_shaper.sv
module rsg_stall_shaper
  import raster_stall_pkg::*;
#(
  parameter int CYC_W        = 6,
  parameter int HEAD_FREE    = 11,
  parameter int WARN_CYCLES  = 3,
  parameter int STEAL_CYCLES = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYC_W-1:0] cyc,
  input  logic             bad_line,
  output logic             ba,
  output logic             aec
);
  localparam logic [CYC_W-1:0] WARN_START  = CYC_W'(HEAD_FREE);
  localparam logic [CYC_W-1:0] STEAL_START = CYC_W'(HEAD_FREE + WARN_CYCLES);
  localparam logic [CYC_W-1:0] STEAL_END   = CYC_W'(HEAD_FREE + WARN_CYCLES + STEAL_CYCLES);

  slot_e slot;

  always_comb begin
    slot = SLOT_FREE;
    if (bad_line) begin
      if (cyc >= STEAL_START && cyc < STEAL_END)      slot = SLOT_STOLEN;
      else if (cyc >= WARN_START && cyc < STEAL_START) slot = SLOT_WONLY;
    end
  end

  assign ba  = (slot == SLOT_FREE);
  assign aec = (slot != SLOT_STOLEN);

  // R6: bus-available only falls at the first warning cycle
  a_r6_ba_fall_pos: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ba) |-> (cyc == WARN_START));

  // R7: address enable only falls after the full warning window
  a_r7_aec_fall_pos: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aec) |-> (cyc == STEAL_START) && !$past(ba) && $past(aec));

  // R8: bus returns at the first cycle after the steal
  a_r8_ba_rise_pos: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ba) |-> (cyc == STEAL_END) && $rose(aec));
endmodule

// File: rtl/raster_stall_gen.sv
module raster_stall_gen #(
  parameter int LINE_CYCLES  = 63,
  parameter int LINE_W       = 9,
  parameter int YS_W         = 3,
  parameter int FIRST_LINE   = 'h30,
  parameter int LAST_LINE    = 'hF7,
  parameter int HEAD_FREE    = 11,
  parameter int WARN_CYCLES  = 3,
  parameter int STEAL_CYCLES = 40,
  parameter int CYC_W        = $clog2(LINE_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] raster_line,
  input  logic [YS_W-1:0]   yscroll,
  input  logic              den,
  output logic              ba,
  output logic              aec,
  output logic              bad_line,
  output logic [CYC_W-1:0]  cycle_idx
);
  logic rst_meta_q, rst_sync_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rsg_cycle_ctr #(
    .LINE_CYCLES (LINE_CYCLES),
    .CYC_W       (CYC_W)
  ) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .cyc_q (cycle_idx)
  );

  rsg_badline_det #(
    .LINE_W     (LINE_W),
    .YS_W       (YS_W),
    .FIRST_LINE (FIRST_LINE),
    .LAST_LINE  (LAST_LINE)
  ) u_det (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .raster_line (raster_line),
    .yscroll     (yscroll),
    .den         (den),
    .bad_line    (bad_line)
  );

  rsg_stall_shaper #(
    .CYC_W        (CYC_W),
    .HEAD_FREE    (HEAD_FREE),
    .WARN_CYCLES  (WARN_CYCLES),
    .STEAL_CYCLES (STEAL_CYCLES)
  ) u_shape (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .cyc      (cycle_idx),
    .bad_line (bad_line),
    .ba       (ba),
    .aec      (aec)
  );

  // R2: held in the idle state while reset is applied
  a_r2_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (cycle_idx == '0) && ba && aec);

  // R3: a bad line never lies outside the display window
  a_r3_window: assert property (@(posedge clk) disable iff (!rst_sync_q)
    bad_line |-> (raster_line >= LINE_W'(FIRST_LINE)) && (raster_line <= LINE_W'(LAST_LINE)));
endmodule

// File: tb/raster_stall_gen_test.sv
module raster_stall_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] raster_line;
  logic [2:0] yscroll;
  logic       den;
  logic       ba, aec, bad_line;
  logic [5:0] cycle_idx;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  raster_stall_gen uut (
    .clk(clk), .rst_n(rst_n), .raster_line(raster_line), .yscroll(yscroll),
    .den(den), .ba(ba), .aec(aec), .bad_line(bad_line), .cycle_idx(cycle_idx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (line %0h cycle %0d)",
               tag, act, exp, raster_line, cycle_idx);
    end
  endtask

  // expected class codes: 0 free, 1 write-only, 2 stolen
  task automatic run_frame(input logic [2:0] ys, input bit den30, input bit den_other,
                           input string den_tag);
    for (int line = 0; line < 312; line++) begin
      bit exp_bad;
      int q[$];
      int head, wonly, stolen, tail;
      raster_line = 9'(line);
      yscroll     = ys;
      den         = (line == 'h30) ? den30 : den_other;
      exp_bad = (line >= 'h30) && (line <= 'hF7) && (line[2:0] == ys) && den30;
      q = {};
      if (exp_bad) begin
        repeat (11) q.push_back(0);
        repeat (3)  q.push_back(1);
        repeat (40) q.push_back(2);
        repeat (9)  q.push_back(0);
      end else begin
        repeat (63) q.push_back(0);
      end
      head = 0; wonly = 0; stolen = 0; tail = 0;
      for (int c = 0; c < 63; c++) begin
        int cls;
        int act_cls;
        cls = q.pop_front();
        @(negedge clk);
        act_cls = (!aec) ? 2 : (!ba ? 1 : 0);
        chk("R1 cycle index", int'(cycle_idx), c);
        chk(den_tag, int'(bad_line), int'(exp_bad));
        if (exp_bad) begin
          if (c < 11)      chk("R5 head free slot", act_cls, cls);
          else if (c < 14) chk("R6 write-only slot", act_cls, cls);
          else if (c < 54) chk("R7 stolen slot", act_cls, cls);
          else             chk("R8 tail free slot", act_cls, cls);
        end else begin
          chk("R9 idle line slot", act_cls, cls);
        end
        if (act_cls == 1) wonly++;
        else if (act_cls == 2) stolen++;
        else if (wonly == 0 && stolen == 0) head++;
        else tail++;
        if (line == 'h83 && ys == 3 && den30 && c == 20)
          chk("R10 line 0x83 bad", int'(bad_line), 1);
        @(posedge clk);
        #1;
      end
      if (exp_bad) begin
        chk("R5 head run", head, 11);
        chk("R6 write-only run", wonly, 3);
        chk("R7 stolen run", stolen, 40);
        chk("R8 tail run", tail, 9);
      end else begin
        chk("R9 free run", head, 63);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    raster_line = '0;
    yscroll = 3'd3;
    den = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset index", int'(cycle_idx), 0);
    chk("R2 reset ba", int'(ba), 1);
    chk("R2 reset aec", int'(aec), 1);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R2 index held after release", int'(cycle_idx), 0);
    @(posedge clk);
    #1;
    run_frame(3'd3, 1'b1, 1'b1, "R3 bad-line flag");
    run_frame(3'd5, 1'b0, 1'b1, "R4 enable outside 0x30 ignored");
    run_frame(3'd0, 1'b1, 1'b0, "R4 enable held after 0x30");
    run_frame(3'd7, 1'b1, 1'b1, "R3 window edges");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule